// File: doc/BRIEF.md
# TLB Range Flush Sequencer

This block turns one request to invalidate a span of virtual addresses into the train of commands a translation lookaside buffer needs. A request carries a start address, an exclusive end address, an address-space identifier (ASID) with a flag telling whether that identifier is currently assigned, and a kernel/user flag. For a short span the sequencer walks the span one page at a time. For each page it issues a delete command whose word holds the page address, with the ASID merged into the low bits for a user span.

When the span reaches a page-count threshold, a page walk would cost more than a wholesale operation, so no per-page deletes are issued. A user span then issues a single new-context command, which tells the owner of ASID allocation to move the context to a fresh identifier. A kernel span runs a full flush instead: a blank write without micro-TLB invalidation to every entry index, then one micro-TLB invalidate.

Requests arrive on a valid/ready port. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. Commands leave on a valid/ready port. A command stays presented, unchanged, until the TLB raises `cmd_ready`, and the TLB may hold `cmd_ready` low for any number of cycles. A one-cycle `done` pulse marks the end of each request.

Top module: `tlb_flush_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: Let span be `req_end - req_start`, computed as unsigned arithmetic modulo 2^ADDR_W on the unaligned start. If span is at least THRESH_PAGES pages, no delete is issued. A user request then issues exactly one new-context command (`cmd_op` = 2, word 0, index 0), and a kernel request performs the full flush of R6. An end below the start wraps to a large span and takes this path.
- R3: Otherwise the start is rounded down to a page boundary and the end is not aligned. One delete (`cmd_op` = 1, index 0) is issued for each page address P, rising in page steps from the rounded start, while P < end. A page that is only partly covered is still deleted, and an aligned start equal to the end issues nothing.
- R4: A user delete word is the page address ORed with the ASID in bits [ASID_W-1:0]. A kernel delete word is the page address alone.
- R5: A user request below the threshold whose `req_asid_valid` is 0 issues no commands, and it still produces its `done` pulse.
- R6: A full flush issues blank writes (`cmd_op` = 3, word 0) to indices 0 through SETS*WAYS-1 in ascending order, then exactly one micro-TLB invalidate (`cmd_op` = 4, word 0, index 0).
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command's op, word and index hold unchanged. Each cycle with both `cmd_valid` and `cmd_ready` high consumes exactly one command.
- R8: `done` is high for exactly one cycle. That cycle is the one after the final command handshake, or the one right after acceptance when the request issues no commands.
- R9: `req_ready` is 0 from the cycle after acceptance through the `done` cycle, and it returns to 1 in the cycle after `done`. A request offered while `req_ready` is 0 is ignored and issues no commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_start | input | ADDR_W | First address of the span (any alignment) |
| req_end | input | ADDR_W | Exclusive end address of the span |
| req_asid | input | ASID_W | Address-space identifier for user spans |
| req_asid_valid | input | 1 | The context currently holds an assigned ASID |
| req_kernel | input | 1 | 1 for a kernel (global) span, 0 for a user span |
| cmd_valid | output | 1 | Command presented to the TLB |
| cmd_ready | input | 1 | TLB takes the presented command |
| cmd_op | output | 3 | 1 delete, 2 new context, 3 blank write, 4 micro-TLB invalidate |
| cmd_word | output | ADDR_W | Page address (with ASID) for delete, otherwise 0 |
| cmd_index | output | IDX_W | Entry index for blank write, otherwise 0 |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Several span shapes are applied, and each one separates one decision:
- An aligned kernel span and an unaligned user span show whether the ASID is merged and whether the partial last page is kept.
- Spans one byte under and exactly at the threshold expose an off-by-one in the size compare.
- A reversed span and an unassigned ASID separate the wrap-to-wholesale path from the silent path.
- An empty aligned span and an empty unaligned span tell the strict end compare apart from an inclusive one.

Each case runs under three `cmd_ready` patterns, so a command that moves while stalled is caught. A second request offered during a full flush shows whether the busy sequencer truly ignores it.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_DELETE = 3'd1,
    OP_NEWCTX = 3'd2,
    OP_BLANK  = 3'd3,
    OP_UINV   = 3'd4
  } tlbf_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELETE,
    ST_NEWCTX,
    ST_BLANK,
    ST_UINV,
    ST_DONE
  } tlbf_state_e;
endpackage

// File: rtl/tlbf_decide.sv
// Classifies an incoming span: wholesale versus page walk, and empty walks.
module tlbf_decide #(
  parameter int ADDR_W       = 32,
  parameter int PAGE_SHIFT   = 13,
  parameter int THRESH_PAGES = 32
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              kernel,
  input  logic              asid_ok,
  output logic [ADDR_W-1:0] first_page,
  output logic              go_wide,
  output logic              no_pages
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(THRESH_PAGES) << PAGE_SHIFT;

  logic [ADDR_W-1:0] span;

  always_comb begin
    span       = end_addr - start_addr;
    go_wide    = {1'b0, span} >= LIMIT;
    first_page = {start_addr[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    no_pages   = (first_page >= end_addr) || (!kernel && !asid_ok);
  end
endmodule

// File: rtl/tlbf_page_walk.sv
// Holds the current page and the exclusive end; flags the final page.
module tlbf_page_walk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_page,
  input  logic [ADDR_W-1:0] load_end,
  output logic [ADDR_W-1:0] page,
  output logic              last
);
  localparam logic [ADDR_W:0] PAGE_INC = (ADDR_W+1)'(1) << PAGE_SHIFT;

  logic [ADDR_W-1:0] page_q, end_q;
  logic [ADDR_W:0]   next_page;

  always_comb begin
    next_page = {1'b0, page_q} + PAGE_INC;
    last      = next_page >= {1'b0, end_q};
    page      = page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      end_q  <= '0;
    end else if (load) begin
      page_q <= load_page;
      end_q  <= load_end;
    end else if (step) begin
      page_q <= next_page[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/tlbf_index_walk.sv
// Entry index counter for the blank-write sweep.
module tlbf_index_walk #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] idx_q;

  assign idx  = idx_q;
  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clear) idx_q <= '0;
    else if (step)  idx_q <= idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/tlb_flush_seq.sv
module tlb_flush_seq
  import tlbf_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int ASID_W       = 8,
  parameter int PAGE_BYTES   = 8192,
  parameter int SETS         = 16,
  parameter int WAYS         = 4,
  parameter int THRESH_PAGES = 32,
  localparam int PAGE_SHIFT  = $clog2(PAGE_BYTES),
  localparam int ENTRIES     = SETS * WAYS,
  localparam int IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_asid_valid,
  input  logic              req_kernel,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_word,
  output logic [IDX_W-1:0]  cmd_index,
  output logic              done
);
  tlbf_state_e       state_q, state_d;
  logic              kernel_q;
  logic [ASID_W-1:0] asid_q;
  logic              accept, hs;
  logic [ADDR_W-1:0] first_page, page;
  logic              go_wide, no_pages, page_last;
  logic [IDX_W-1:0]  idx;
  logic              idx_last;
  tlbf_op_e          op;

  tlbf_decide #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .THRESH_PAGES(THRESH_PAGES)
  ) u_decide (
    .start_addr(req_start), .end_addr(req_end), .kernel(req_kernel),
    .asid_ok(req_asid_valid), .first_page(first_page), .go_wide(go_wide),
    .no_pages(no_pages)
  );

  tlbf_page_walk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_pages (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .step(hs && (state_q == ST_DELETE)),
    .load_page(first_page), .load_end(req_end),
    .page(page), .last(page_last)
  );

  tlbf_index_walk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .step(hs && (state_q == ST_BLANK)),
    .idx(idx), .last(idx_last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hs        = cmd_valid && cmd_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (accept) begin
          if (go_wide)       state_d = req_kernel ? ST_BLANK : ST_NEWCTX;
          else if (no_pages) state_d = ST_DONE;
          else               state_d = ST_DELETE;
        end
      ST_DELETE: if (hs && page_last) state_d = ST_DONE;
      ST_NEWCTX: if (hs)              state_d = ST_DONE;
      ST_BLANK:  if (hs && idx_last)  state_d = ST_UINV;
      ST_UINV:   if (hs)              state_d = ST_DONE;
      ST_DONE:                        state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kernel_q <= 1'b0;
      asid_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kernel_q <= req_kernel;
        asid_q   <= req_asid;
      end
    end
  end

  always_comb begin
    op        = OP_NONE;
    cmd_word  = '0;
    cmd_index = '0;
    unique case (state_q)
      ST_DELETE: begin
        op       = OP_DELETE;
        cmd_word = kernel_q ? page
                            : (page | {{(ADDR_W-ASID_W){1'b0}}, asid_q});
      end
      ST_NEWCTX: op = OP_NEWCTX;
      ST_BLANK: begin
        op        = OP_BLANK;
        cmd_index = idx;
      end
      ST_UINV:   op = OP_UINV;
      default:   op = OP_NONE;
    endcase
  end

  assign cmd_op    = op;
  assign cmd_valid = (op != OP_NONE);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker #(
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 13,
  parameter int ENTRIES    = 64,
  parameter int IDX_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_word,
  input logic [IDX_W-1:0]  cmd_index,
  input logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) &&
                                $stable(cmd_word) && $stable(cmd_index));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || done) |-> !req_ready);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  del_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd1) |-> (cmd_word[PAGE_SHIFT-1:ASID_W] == '0));

  // R6
  blank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && (cmd_op == 3'd3) |-> (cmd_index == '0));

  // R6
  blank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_op == 3'd3) |=>
      cmd_valid && (((cmd_op == 3'd3) && (cmd_index == $past(cmd_index) + IDX_W'(1))) ||
                    ((cmd_op == 3'd4) && ($past(cmd_index) == LAST_IDX))));

  // R8
  uinv_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_op == 3'd4) |=> done);
endmodule

bind tlb_flush_seq tlbf_checker #(
  .ADDR_W(ADDR_W), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT),
  .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_word(cmd_word), .cmd_index(cmd_index), .done(done)
);

// File: tb/test_tlb_flush_seq.sv
module test_tlb_flush_seq;
  localparam int PAGE    = 8192;
  localparam int ENTRIES = 64;
  localparam int IDX_W   = 6;
  localparam int THRESH  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_start = '0, req_end = '0;
  logic [7:0]  req_asid = '0;
  logic        req_asid_valid = 1'b0, req_kernel = 1'b0;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_word;
  logic [IDX_W-1:0] cmd_index;
  logic        done;

  typedef struct packed {
    logic [2:0]       op;
    logic [31:0]      word;
    logic [IDX_W-1:0] idx;
  } item_t;

  item_t exp_q[$];
  int    checks = 0, errors = 0, cyc = 0, last_hs_cyc = 0, stall_mode = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tlb_flush_seq i_tlb_flush_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .req_asid(req_asid),
    .req_asid_valid(req_asid_valid), .req_kernel(req_kernel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_word(cmd_word), .cmd_index(cmd_index), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: drives cmd_ready and compares every handshake with the queue.
  always @(negedge clk) begin
    bit    r;
    item_t e;
    case (stall_mode)
      0:       r = 1'b1;
      1:       r = cyc[0];
      default: r = (cyc % 3) != 0;
    endcase
    cmd_ready = r;
    if (cmd_valid && r) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected command", longint'({cmd_op, cmd_word}), 0);
      end else begin
        e = exp_q.pop_front();
        check(cmd_op == e.op && cmd_word == e.word && cmd_index == e.idx, cur_req,
              "command op/word/index", longint'({cmd_op, cmd_word, cmd_index}),
              longint'(e));
      end
      last_hs_cyc = cyc;
    end
  end

  task automatic run(input logic [31:0] s, input logic [31:0] e, input logic [7:0] asid,
                     input bit asid_ok, input bit kern, input string req, input bit poke);
    logic [31:0] span;
    longint      a;
    int          nexp, d, t, exp_c;
    span = e - s;
    nexp = 0;
    cur_req = req;
    if (longint'(span) >= longint'(THRESH * PAGE)) begin
      if (kern) begin
        for (int i = 0; i < ENTRIES; i++) begin
          exp_q.push_back('{op: 3'd3, word: 32'd0, idx: IDX_W'(i)});
          nexp++;
        end
        exp_q.push_back('{op: 3'd4, word: 32'd0, idx: '0});
        nexp++;
      end else begin
        exp_q.push_back('{op: 3'd2, word: 32'd0, idx: '0});
        nexp++;
      end
    end else if (kern || asid_ok) begin
      a = longint'({s[31:13], 13'd0});
      while (a < longint'(e)) begin
        exp_q.push_back('{op: 3'd1,
                          word: 32'(a) | (kern ? 32'd0 : {24'd0, asid}), idx: '0});
        nexp++;
        a = a + PAGE;
      end
    end
    while (!req_ready) @(negedge clk);
    req_start = s; req_end = e; req_asid = asid;
    req_asid_valid = asid_ok; req_kernel = kern; req_valid = 1'b1;
    d = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R9: a second request while busy must be ignored
      req_start = 32'h0000_0000; req_end = 32'h0000_4000; req_kernel = 1'b1;
      req_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        check(req_ready == 1'b0, "R9", "req_ready while busy", longint'(req_ready), 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    exp_c = (nexp == 0) ? d + 1 : last_hs_cyc + 1;
    check(done == 1'b1, "R8", "done arrived", longint'(done), 1);
    check(cyc == exp_c, "R8", "done cycle", longint'(cyc), longint'(exp_c));
    check(req_ready == 1'b0, "R9", "req_ready in done cycle", longint'(req_ready), 0);
    check(exp_q.size() == 0, req, "commands left over", longint'(exp_q.size()), 0);
    exp_q.delete();
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle only", longint'(done), 0);
    check(req_ready == 1'b1, "R9", "req_ready after done", longint'(req_ready), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", longint'(req_ready), 1);
    check(cmd_valid == 1'b0, "R1", "cmd_valid", longint'(cmd_valid), 0);
    check(done == 1'b0, "R1", "done", longint'(done), 0);

    stall_mode = 0;
    run(32'h4000_0000, 32'h4000_6000, 8'h11, 1'b1, 1'b1, "R4", 1'b0);   // kernel words, no ASID
    stall_mode = 1;
    run(32'h1000_1234, 32'h1000_1234 + 2*PAGE + 5, 8'h5A, 1'b1, 1'b0, "R3", 1'b0);
    run(32'h2000_0000, 32'h2000_8000, 8'h33, 1'b0, 1'b0, "R5", 1'b0);    // no ASID
    stall_mode = 2;
    run(32'h3000_0000, 32'h3000_0000 + THRESH*PAGE, 8'h07, 1'b1, 1'b0, "R2", 1'b0);
    run(32'h3000_0100, 32'h3000_0100 + THRESH*PAGE - 1, 8'h07, 1'b1, 1'b0, "R2", 1'b0);
    run(32'h5000_0000, 32'h5010_0000, 8'h00, 1'b0, 1'b1, "R6", 1'b1);   // full flush + poke
    stall_mode = 1;
    run(32'h7000_0ABC, 32'h7000_0ABC, 8'h44, 1'b1, 1'b0, "R3", 1'b0);   // one partial page
    run(32'h7000_2000, 32'h7000_2000, 8'h44, 1'b1, 1'b0, "R3", 1'b0);   // empty
    run(32'h8000_4000, 32'h8000_1000, 8'h01, 1'b1, 1'b0, "R2", 1'b0);   // wrapped span
    stall_mode = 0;
    run(32'h9000_0000, 32'hA000_0000, 8'h00, 1'b1, 1'b1, "R7", 1'b0);   // full flush, no stall
    run(32'hB000_1FFF, 32'hB000_2001, 8'hC3, 1'b1, 1'b0, "R4", 1'b0);   // two pages with ASID

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule